// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the data path around a single accumulator register. Each clock cycle it takes a 4-bit command and a 2-bit operand source select. It combines the accumulator with the chosen second operand, or works on the accumulator alone, and writes the result back. The second operand comes from one of four places: memory read data, an immediate value carried by the instruction, the register file read port, or a built-in constant of one. The constant lets the same add and subtract commands act as increment and decrement.

Alongside the accumulator the block keeps four condition flags: zero, signed overflow, carry and equal. A sequencer outside the block tests them to decide conditional branches. A 3-bit clear field can clear the zero, overflow and carry flags one at a time, in the same cycle as any command. Commands are also provided to hold the accumulator, load it from the selected source, or zero it, so the sequencer can drive the unit on every instruction.

Top module: `acc_dpu`

## Requirements
- R1: While rst_n is low, the accumulator and all four flags are cleared to zero, and they stay zero in the first cycle after reset is released.
- R2: Command 0000 adds the operand to the accumulator. Carry takes the carry out of bit 7. Overflow is set when both inputs have the same sign and the sign of the result differs from it. Zero is set when the 8-bit result is 0. Equal is unchanged.
- R3: Command 0001 subtracts the operand from the accumulator. Carry takes the borrow, which is set when the accumulator is below the operand as an unsigned value. Overflow is set when the input signs differ and the sign of the result differs from the accumulator's sign. Zero follows the result, and equal is set exactly when the accumulator equalled the operand.
- R4: Operand select 00 picks mem_data, 01 picks imm_data, 10 picks reg_data and 11 picks the constant 1. Add and subtract with select 11 therefore act as increment and decrement.
- R5: Command 0010 holds the accumulator. Command 0011 loads it with the selected operand. Command 1101 sets it to zero. None of these three changes any flag.
- R6: Commands 0100 AND, 0101 OR, 0110 XOR and 1100 NOT (~A) update only the zero flag. NOT ignores the operand.
- R7: Command 0111 gives {A[7], A[7:1]}. Command 1000 keeps the sign bit and gives {A[7], A[5:0], 0}. Both update only the zero flag.
- R8: Command 1010 shifts left logically to give {A[6:0], 0}. Command 1011 shifts right logically to give {0, A[7:1]}. Both update only the zero flag.
- R9: Command 1001 gives the two's-complement negation ~A + 1 and updates only the zero flag.
- R10: Command 1110 gives {C, A[7:1]} and sets the new carry to A[0]. Command 1111 gives {A[6:0], C} and sets the new carry to A[7]. Both also update the zero flag.
- R11: flag_clr bit 0 clears zero, bit 1 clears overflow and bit 2 clears carry at the next edge with any command. A clear bit overrides an update of the same flag in that cycle. The equal flag has no clear bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 4 | Operation command |
| src_sel | input | 2 | Second operand source select |
| mem_data | input | 8 | Memory read data |
| imm_data | input | 8 | Immediate operand from the instruction |
| reg_data | input | 8 | Register file read data |
| flag_clr | input | 3 | Per-flag clear: bit 0 zero, bit 1 overflow, bit 2 carry |
| acc_out | output | 8 | Accumulator value |
| flag_z | output | 1 | Zero flag |
| flag_ov | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry / borrow flag |
| flag_eq | output | 1 | Equal flag |

## Verification
The hardest case to reach is a cycle in which a clear bit meets an update of the same flag. To show that the clear wins, the command must on its own set that flag. The stimulus therefore loads 0xFF, then increments with the carry clear bit raised. That add carries out, so a design that let the update win would leave carry set. Rotates get the same treatment: the carry-in is first forced to a known value with a clear, so each rotate shows exactly which bit enters and which bit leaves.

// File: rtl/acc_dpu_pkg.sv
package acc_dpu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'b0000,
        OP_SUB  = 4'b0001,
        OP_HOLD = 4'b0010,
        OP_LOAD = 4'b0011,
        OP_AND  = 4'b0100,
        OP_OR   = 4'b0101,
        OP_XOR  = 4'b0110,
        OP_ASR  = 4'b0111,
        OP_ASL  = 4'b1000,
        OP_NEG  = 4'b1001,
        OP_SLL  = 4'b1010,
        OP_SRL  = 4'b1011,
        OP_NOT  = 4'b1100,
        OP_ZERO = 4'b1101,
        OP_RRC  = 4'b1110,
        OP_RLC  = 4'b1111
    } acc_op_e;

    typedef enum logic [1:0] {
        SRC_MEM = 2'b00,
        SRC_IMM = 2'b01,
        SRC_REG = 2'b10,
        SRC_ONE = 2'b11
    } acc_src_e;

    typedef struct packed {
        logic z;
        logic ov;
        logic c;
        logic eq;
    } acc_flags_t;

    localparam int CLR_Z_BIT  = 0;
    localparam int CLR_OV_BIT = 1;
    localparam int CLR_C_BIT  = 2;
    localparam int CLR_W      = 3;

endpackage

// File: rtl/acc_src_mux.sv
module acc_src_mux
    import acc_dpu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] mem_data,
    input  logic [W-1:0] imm_data,
    input  logic [W-1:0] reg_data,
    output logic [W-1:0] operand
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (acc_src_e'(sel))
            SRC_MEM: operand = mem_data;
            SRC_IMM: operand = imm_data;
            SRC_REG: operand = reg_data;
            default: operand = ONE;
        endcase
    end
endmodule

// File: rtl/acc_exec_core.sv
module acc_exec_core
    import acc_dpu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   cmd,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] operand,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output acc_flags_t   new_flags,
    output acc_flags_t   upd_mask
);
    localparam int MSB = W - 1;

    logic [W:0] sum_w;
    logic [W:0] diff_w;

    assign sum_w  = {1'b0, acc} + {1'b0, operand};
    assign diff_w = {1'b0, acc} - {1'b0, operand};

    always_comb begin
        result       = acc;
        new_flags    = '0;
        upd_mask     = '0;
        unique case (acc_op_e'(cmd))
            OP_ADD: begin
                result       = sum_w[MSB:0];
                new_flags.c  = sum_w[W];
                new_flags.ov = (acc[MSB] == operand[MSB]) && (sum_w[MSB] != acc[MSB]);
                upd_mask.z   = 1'b1;
                upd_mask.ov  = 1'b1;
                upd_mask.c   = 1'b1;
            end
            OP_SUB: begin
                result       = diff_w[MSB:0];
                new_flags.c  = diff_w[W];
                new_flags.ov = (acc[MSB] != operand[MSB]) && (diff_w[MSB] != acc[MSB]);
                new_flags.eq = (acc == operand);
                upd_mask     = '1;
            end
            OP_HOLD: result = acc;
            OP_LOAD: result = operand;
            OP_AND: begin
                result     = acc & operand;
                upd_mask.z = 1'b1;
            end
            OP_OR: begin
                result     = acc | operand;
                upd_mask.z = 1'b1;
            end
            OP_XOR: begin
                result     = acc ^ operand;
                upd_mask.z = 1'b1;
            end
            OP_ASR: begin
                result     = {acc[MSB], acc[MSB:1]};
                upd_mask.z = 1'b1;
            end
            OP_ASL: begin
                result     = {acc[MSB], acc[MSB-2:0], 1'b0};
                upd_mask.z = 1'b1;
            end
            OP_NEG: begin
                result     = ~acc + 1'b1;
                upd_mask.z = 1'b1;
            end
            OP_SLL: begin
                result     = {acc[MSB-1:0], 1'b0};
                upd_mask.z = 1'b1;
            end
            OP_SRL: begin
                result     = {1'b0, acc[MSB:1]};
                upd_mask.z = 1'b1;
            end
            OP_NOT: begin
                result     = ~acc;
                upd_mask.z = 1'b1;
            end
            OP_ZERO: result = '0;
            OP_RRC: begin
                result      = {carry_in, acc[MSB:1]};
                new_flags.c = acc[0];
                upd_mask.z  = 1'b1;
                upd_mask.c  = 1'b1;
            end
            default: begin
                result      = {acc[MSB-1:0], carry_in};
                new_flags.c = acc[MSB];
                upd_mask.z  = 1'b1;
                upd_mask.c  = 1'b1;
            end
        endcase
        new_flags.z = (result == '0);
    end
endmodule

// File: rtl/acc_dpu.sv
module acc_dpu
    import acc_dpu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   cmd,
    input  logic [1:0]   src_sel,
    input  logic [W-1:0] mem_data,
    input  logic [W-1:0] imm_data,
    input  logic [W-1:0] reg_data,
    input  logic [2:0]   flag_clr,
    output logic [W-1:0] acc_out,
    output logic         flag_z,
    output logic         flag_ov,
    output logic         flag_c,
    output logic         flag_eq
);
    typedef struct packed {
        logic [W-1:0] acc;
        acc_flags_t   flags;
    } dpu_state_t;

    dpu_state_t   st_d, st_q;
    logic [W-1:0] operand;
    logic [W-1:0] result;
    acc_flags_t   new_flags;
    acc_flags_t   upd_mask;

    acc_src_mux #(.W(W)) u_mux (
        .sel      (src_sel),
        .mem_data (mem_data),
        .imm_data (imm_data),
        .reg_data (reg_data),
        .operand  (operand)
    );

    acc_exec_core #(.W(W)) u_core (
        .cmd       (cmd),
        .acc       (st_q.acc),
        .operand   (operand),
        .carry_in  (st_q.flags.c),
        .result    (result),
        .new_flags (new_flags),
        .upd_mask  (upd_mask)
    );

    always_comb begin
        st_d          = st_q;
        st_d.acc      = result;
        st_d.flags.z  = upd_mask.z  ? new_flags.z  : st_q.flags.z;
        st_d.flags.ov = upd_mask.ov ? new_flags.ov : st_q.flags.ov;
        st_d.flags.c  = upd_mask.c  ? new_flags.c  : st_q.flags.c;
        st_d.flags.eq = upd_mask.eq ? new_flags.eq : st_q.flags.eq;
        if (flag_clr[CLR_Z_BIT])  st_d.flags.z  = 1'b0;
        if (flag_clr[CLR_OV_BIT]) st_d.flags.ov = 1'b0;
        if (flag_clr[CLR_C_BIT])  st_d.flags.c  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_out = st_q.acc;
    assign flag_z  = st_q.flags.z;
    assign flag_ov = st_q.flags.ov;
    assign flag_c  = st_q.flags.c;
    assign flag_eq = st_q.flags.eq;

    // R1: reset leaves everything zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && !flag_z && !flag_ov && !flag_c && !flag_eq));

    // R11: each clear bit forces its flag low at the next edge
    a_r11_clear_z: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr[CLR_Z_BIT] |=> !flag_z);
    a_r11_clear_ov: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr[CLR_OV_BIT] |=> !flag_ov);
    a_r11_clear_c: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr[CLR_C_BIT] |=> !flag_c);

    // R5: hold keeps accumulator and flags
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == OP_HOLD && flag_clr == '0) |=>
        ($stable(acc_out) && $stable(flag_z) && $stable(flag_ov) && $stable(flag_c) && $stable(flag_eq)));

    // R3: equal flag after subtract reflects operand comparison
    a_r3_eq_on_sub: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == OP_SUB |=> flag_eq == ($past(acc_out) == $past(operand)));

    // R10: rotate right moves bit 0 into carry
    a_r10_rrc_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == OP_RRC && !flag_clr[CLR_C_BIT]) |=> flag_c == $past(acc_out[0]));

    // R6: logic commands leave carry and overflow untouched
    a_r6_logic_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == OP_AND || cmd == OP_OR || cmd == OP_XOR || cmd == OP_NOT) && flag_clr == '0)
        |=> ($stable(flag_c) && $stable(flag_ov) && $stable(flag_eq)));

    // R4: select 11 with add increments
    a_r4_inc_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == OP_ADD && src_sel == SRC_ONE) |=> acc_out == $past(acc_out) + 1'b1);
endmodule

// File: tb/acc_dpu_test.sv
module acc_dpu_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd = 4'b0010;
    logic [1:0] src_sel = 2'b00;
    logic [7:0] mem_data = 8'h00;
    logic [7:0] imm_data = 8'h00;
    logic [7:0] reg_data = 8'h00;
    logic [2:0] flag_clr = 3'b000;
    logic [7:0] acc_out;
    logic       flag_z, flag_ov, flag_c, flag_eq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    acc_dpu uut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .src_sel(src_sel),
        .mem_data(mem_data), .imm_data(imm_data), .reg_data(reg_data),
        .flag_clr(flag_clr), .acc_out(acc_out), .flag_z(flag_z),
        .flag_ov(flag_ov), .flag_c(flag_c), .flag_eq(flag_eq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic op(input logic [3:0] c, input logic [1:0] s,
                      input logic [7:0] m, input logic [7:0] i,
                      input logic [7:0] r, input logic [2:0] clr);
        @(negedge clk);
        cmd = c; src_sel = s; mem_data = m; imm_data = i; reg_data = r; flag_clr = clr;
        @(posedge clk);
        #1;
        cmd = 4'b0010; flag_clr = 3'b000;
    endtask

    task automatic expect_st(input logic [7:0] a, input logic z, input logic ov,
                             input logic c, input logic eq, input string tag);
        checks++;
        if (acc_out !== a || flag_z !== z || flag_ov !== ov || flag_c !== c || flag_eq !== eq) begin
            fails++;
            $display("FAIL %s: got acc=%h z%b ov%b c%b eq%b, expected acc=%h z%b ov%b c%b eq%b",
                     tag, acc_out, flag_z, flag_ov, flag_c, flag_eq, a, z, ov, c, eq);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_st(8'h00, 0, 0, 0, 0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_st(8'h00, 0, 0, 0, 0, "R1 after release");
    endtask

    task automatic t_add();
        op(4'b0011, 2'b01, 8'h00, 8'h7F, 8'h00, 3'b000);
        expect_st(8'h7F, 0, 0, 0, 0, "R5 load imm");
        op(4'b0000, 2'b11, 8'hAA, 8'hAA, 8'hAA, 3'b000);
        expect_st(8'h80, 0, 1, 0, 0, "R4 R2 increment overflow");
        op(4'b0000, 2'b01, 8'h00, 8'h80, 8'h00, 3'b000);
        expect_st(8'h00, 1, 1, 1, 0, "R2 add carry zero");
    endtask

    task automatic t_clear_all();
        op(4'b0010, 2'b00, 8'h00, 8'h00, 8'h00, 3'b111);
        expect_st(8'h00, 0, 0, 0, 0, "R11 clear all");
    endtask

    task automatic t_sub();
        op(4'b0001, 2'b11, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'hFF, 0, 0, 1, 0, "R4 R3 decrement borrow");
        op(4'b0011, 2'b00, 8'h3C, 8'h00, 8'h00, 3'b000);
        expect_st(8'h3C, 0, 0, 1, 0, "R5 load mem keeps flags");
        op(4'b0001, 2'b00, 8'h3C, 8'h11, 8'h22, 3'b000);
        expect_st(8'h00, 1, 0, 0, 1, "R3 sub equal");
        op(4'b0010, 2'b10, 8'h99, 8'h98, 8'h97, 3'b000);
        expect_st(8'h00, 1, 0, 0, 1, "R5 hold");
    endtask

    task automatic t_clear_priority();
        op(4'b0011, 2'b01, 8'h00, 8'hFF, 8'h00, 3'b000);
        expect_st(8'hFF, 1, 0, 0, 1, "R5 load keeps flags");
        op(4'b0000, 2'b11, 8'h00, 8'h00, 8'h00, 3'b100);
        expect_st(8'h00, 1, 0, 0, 1, "R11 clear beats carry update");
        op(4'b0001, 2'b10, 8'h00, 8'h00, 8'h80, 3'b000);
        expect_st(8'h80, 0, 1, 1, 0, "R3 sub reg borrow overflow");
    endtask

    task automatic t_logic();
        op(4'b0011, 2'b01, 8'h00, 8'hF0, 8'h00, 3'b000);
        op(4'b0100, 2'b10, 8'h00, 8'h00, 8'h3C, 3'b000);
        expect_st(8'h30, 0, 1, 1, 0, "R6 and");
        op(4'b0101, 2'b00, 8'h0F, 8'h00, 8'h00, 3'b000);
        expect_st(8'h3F, 0, 1, 1, 0, "R6 or");
        op(4'b0110, 2'b01, 8'h00, 8'h3F, 8'h00, 3'b000);
        expect_st(8'h00, 1, 1, 1, 0, "R6 xor zero");
        op(4'b1100, 2'b01, 8'h12, 8'h34, 8'h56, 3'b000);
        expect_st(8'hFF, 0, 1, 1, 0, "R6 not ignores operand");
    endtask

    task automatic t_shifts();
        op(4'b0011, 2'b01, 8'h00, 8'h96, 8'h00, 3'b000);
        op(4'b0111, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'hCB, 0, 1, 1, 0, "R7 arith right");
        op(4'b0011, 2'b01, 8'h00, 8'h96, 8'h00, 3'b000);
        op(4'b1000, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'hAC, 0, 1, 1, 0, "R7 arith left keeps sign");
        op(4'b0011, 2'b01, 8'h00, 8'h41, 8'h00, 3'b000);
        op(4'b1000, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'h02, 0, 1, 1, 0, "R7 arith left drops bit 6");
        op(4'b0011, 2'b01, 8'h00, 8'h96, 8'h00, 3'b000);
        op(4'b1010, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'h2C, 0, 1, 1, 0, "R8 logical left");
        op(4'b0011, 2'b01, 8'h00, 8'h96, 8'h00, 3'b000);
        op(4'b1011, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'h4B, 0, 1, 1, 0, "R8 logical right");
        op(4'b0011, 2'b01, 8'h00, 8'h01, 8'h00, 3'b000);
        op(4'b1011, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'h00, 1, 1, 1, 0, "R8 logical right to zero");
    endtask

    task automatic t_negate();
        op(4'b0011, 2'b01, 8'h00, 8'h05, 8'h00, 3'b000);
        op(4'b1001, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'hFB, 0, 1, 1, 0, "R9 negate");
        op(4'b0011, 2'b01, 8'h00, 8'h55, 8'h00, 3'b000);
        op(4'b1101, 2'b01, 8'h00, 8'h77, 8'h00, 3'b000);
        expect_st(8'h00, 0, 1, 1, 0, "R5 zero acc keeps flags");
        op(4'b1001, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'h00, 1, 1, 1, 0, "R9 negate zero");
    endtask

    task automatic t_rotate();
        op(4'b0010, 2'b00, 8'h00, 8'h00, 8'h00, 3'b111);
        op(4'b0011, 2'b01, 8'h00, 8'h81, 8'h00, 3'b000);
        op(4'b1110, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'h40, 0, 0, 1, 0, "R10 rrc");
        op(4'b1111, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'h81, 0, 0, 0, 0, "R10 rlc carry in");
        op(4'b1111, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'h02, 0, 0, 1, 0, "R10 rlc carry out");
        op(4'b0011, 2'b01, 8'h00, 8'h01, 8'h00, 3'b100);
        op(4'b1110, 2'b00, 8'h00, 8'h00, 8'h00, 3'b000);
        expect_st(8'h00, 1, 0, 1, 0, "R10 rrc to zero");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add();
        t_clear_all();
        t_sub();
        t_clear_priority();
        t_logic();
        t_shifts();
        t_negate();
        t_rotate();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule